// File: doc/BRIEF.md
# Scan-List Acquisition Sequencer

This block is the register front end of a multichannel analog acquisition engine, reached over an 8-bit host bus. Software loads a queue of 16-bit scan-list entries. Each entry names a channel, a gain code, a single-ended or differential input, and whether it opens a new scan. Software then arms the sequencer. On every pacer tick the sequencer hands the current entry to the converter. When the converter returns a result, the sequencer writes that 16-bit word into a sample FIFO and moves on to the next entry.

The host empties the FIFO as byte pairs through one port. A status byte reports live conditions and latched events, and the latched events clear when the status byte is read. The command byte carries one-shot strobes that start, stop and reset the engine. The FIFO near-full threshold is set by writing bytes to the FIFO port right after a FIFO reset. One interrupt line combines the pending events that software has enabled.

Top module: `scan_acq_seq`

## Requirements
- R1: After reset the status byte reads 0x81 (idle, FIFO empty), the command byte reads 0x00 and irq is low.
- R2: A scan-list entry is built from two writes to the queue port (address 1), low byte first. The entry presented on conv_entry when conv_start pulses equals the assembled word. In an entry, bit 14 is differential, bits 13:12 are gain, bits 11:8 are channel, bit 7 is scan start, bits 5:4 are external gain and bits 3:0 are external channel.
- R3: A command write with bit 7 set arms the sequencer, and the status byte (address 2) then shows running (bit 6) and not idle (bit 7). Each pacer tick while running and not converting issues one conv_start for the next entry. In one-shot mode (control bit 2 clear) the sequencer returns to idle after the last entry, and later ticks issue nothing.
- R4: With control bit 2 set, the sequencer wraps from the last entry back to the first.
- R5: The end-of-scan event (status bit 4) is set when a conversion completes for the last entry, or for an entry whose successor has bit 7 set.
- R6: Reading the FIFO port (address 0) returns the oldest word as a low byte and then a high byte. The word is removed on the high-byte read, in arrival order. An empty FIFO reads 0.
- R7: Status bits 5, 4 and 3 clear when the status byte is read. Bits 7, 6, 2, 1 and 0 follow live state.
- R8: Command bits 7 (arm), 6 (FIFO reset), 5 (queue reset) and 4 (stop) act once and are not stored. Reading the command byte (address 3) returns only bit 0, the FIFO data-mode bit.
- R9: After a FIFO reset with command bit 0 clear, the first four bytes written to the FIFO port form two little-endian words. The first is the near-empty threshold and has no effect. The second is the near-full value V. Further writes are ignored. Status bit 1 is set when depth minus count is at most V. Status bit 3 is latched when a push makes that condition true.
- R10: Status bit 2 shows a full FIFO. A result that arrives while the FIFO is full is dropped and sets the data-lost event (bit 5). The stored words are not changed.
- R11: irq is the OR of end-of-scan pending with control bit 4 and threshold pending with control bit 3. It drops after a status read clears those events.
- R12: A stop command halts the sequencer. Later ticks issue no conv_start and the status byte shows idle.
- R13: A queue reset empties the scan list, and an arm command given with an empty list is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select: 0 FIFO, 1 queue, 2 control/status, 3 command |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe (read side effects take place at the edge) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| pacer_tick | input | 1 | Conversion pacing pulse |
| conv_start | output | 1 | One-cycle request to the converter |
| conv_entry | output | 16 | Scan-list entry being converted |
| conv_valid | input | 1 | Converter result strobe |
| conv_data | input | 16 | Converter result |
| irq | output | 1 | Interrupt request |

## Verification
The assertions watch properties that hold on every cycle: a start request never lasts two cycles, a start only follows a running state, the command byte never reads back a strobe bit, the FIFO is never both full and empty and never holds more words than its depth, and irq is low after any status read that no conversion coincides with. The directed scenarios cover the rest. These are the entry order seen by the converter, one-shot completion against continuous wrap, where end-of-scan fires, threshold programming through the FIFO port, dropping a result on a full FIFO without changing stored data, and arm with an empty list.

// File: rtl/scan_acq_pkg.sv
package scan_acq_pkg;
    localparam logic [1:0] ADDR_FIFO  = 2'd0;
    localparam logic [1:0] ADDR_QUEUE = 2'd1;
    localparam logic [1:0] ADDR_CSR   = 2'd2;
    localparam logic [1:0] ADDR_CMD   = 2'd3;

    localparam int CMD_ARM   = 7;
    localparam int CMD_FRST  = 6;
    localparam int CMD_QRST  = 5;
    localparam int CMD_STOP  = 4;
    localparam int CMD_DMODE = 0;

    localparam int CTL_EOS_EN = 4;
    localparam int CTL_THR_EN = 3;
    localparam int CTL_CONT   = 2;

    localparam int ENT_START = 7;

    typedef struct packed {
        logic eos_en;
        logic thr_en;
        logic cont;
    } ctrl_t;

    typedef struct packed {
        logic lost;
        logic eos;
        logic thr;
    } evt_t;
endpackage

// File: rtl/sample_fifo.sv
module sample_fifo #(
    parameter int DEPTH = 4096,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [15:0]   push_data,
    input  logic          pop,
    output logic [15:0]   head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } fst_t;

    fst_t st_d, st_q;
    logic [15:0] mem [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        full    = (st_q.cnt == CW'(DEPTH));
        empty   = (st_q.cnt == '0);
        do_push = push && !full && !clr;
        do_pop  = pop && !empty && !clr;
        st_d    = st_q;
        if (do_push) st_d.wr = st_q.wr + 1'b1;
        if (do_pop)  st_d.rd = st_q.rd + 1'b1;
        if (do_push && !do_pop) st_d.cnt = st_q.cnt + 1'b1;
        if (do_pop && !do_push) st_d.cnt = st_q.cnt - 1'b1;
        if (clr) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wr] <= push_data;
    end

    assign head  = mem[st_q.rd];
    assign count = st_q.cnt;
endmodule

// File: rtl/scan_queue.sv
module scan_queue #(
    parameter int DEPTH = 2048,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [7:0]    wr_byte,
    input  logic [IW-1:0] rd_idx,
    output logic [15:0]   rd_entry,
    input  logic [IW-1:0] nx_idx,
    output logic          nx_start,
    output logic [IW:0]   len
);
    typedef struct packed {
        logic [7:0] lo;
        logic       hi_phase;
        logic [IW:0] len;
    } qst_t;

    qst_t st_d, st_q;
    logic [15:0] mem [DEPTH];
    logic commit;

    always_comb begin
        commit = wr_en && st_q.hi_phase && (st_q.len < (IW+1)'(DEPTH)) && !clr;
        st_d   = st_q;
        if (wr_en) begin
            if (!st_q.hi_phase) st_d.lo = wr_byte;
            st_d.hi_phase = !st_q.hi_phase;
        end
        if (commit) st_d.len = st_q.len + 1'b1;
        if (clr) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (commit) mem[st_q.len[IW-1:0]] <= {wr_byte, st_q.lo};
    end

    assign rd_entry = mem[rd_idx];
    assign nx_start = mem[nx_idx][scan_acq_pkg::ENT_START];
    assign len      = st_q.len;
endmodule

// File: rtl/scan_acq_seq.sv
module scan_acq_seq
    import scan_acq_pkg::*;
#(
    parameter int FIFO_DEPTH  = 4096,
    parameter int QUEUE_DEPTH = 2048
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic        pacer_tick,
    output logic        conv_start,
    output logic [15:0] conv_entry,
    input  logic        conv_valid,
    input  logic [15:0] conv_data,
    output logic        irq
);
    localparam int QI_W = $clog2(QUEUE_DEPTH);
    localparam int FC_W = $clog2(FIFO_DEPTH) + 1;

    typedef struct packed {
        logic            running;
        logic            busy;
        logic            start;
        logic [QI_W-1:0] idx;
        ctrl_t           ctrl;
        logic            data_mode;
        evt_t            evt;
        logic [2:0]      prog_cnt;
        logic [7:0]      nf_lo;
        logic [15:0]     nf_val;
        logic            rd_hi;
    } st_t;

    st_t st_d, st_q;

    logic            cmd_wr, arm, frst, qrst, stop, csr_rd;
    logic            done, push, pop, last;
    logic            fifo_full, fifo_empty, nx_start;
    logic [15:0]     fifo_head;
    logic [FC_W-1:0] fifo_count;
    logic [QI_W:0]   q_len;
    logic [QI_W-1:0] nx_idx;
    logic [31:0]     free_now, free_after;
    logic            nf_now, thr_set;
    logic [7:0]      status;
    logic            running_w;
    evt_t            evt_set;

    scan_queue #(.DEPTH(QUEUE_DEPTH)) queue_i (
        .clk(clk), .rst_n(rst_n), .clr(qrst),
        .wr_en(bus_wr && bus_addr == ADDR_QUEUE), .wr_byte(bus_wdata),
        .rd_idx(st_q.idx), .rd_entry(conv_entry),
        .nx_idx(nx_idx), .nx_start(nx_start), .len(q_len)
    );

    sample_fifo #(.DEPTH(FIFO_DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n), .clr(frst),
        .push(push), .push_data(conv_data), .pop(pop),
        .head(fifo_head), .count(fifo_count),
        .full(fifo_full), .empty(fifo_empty)
    );

    always_comb begin
        cmd_wr = bus_wr && bus_addr == ADDR_CMD;
        arm    = cmd_wr && bus_wdata[CMD_ARM];
        frst   = cmd_wr && bus_wdata[CMD_FRST];
        qrst   = cmd_wr && bus_wdata[CMD_QRST];
        stop   = cmd_wr && bus_wdata[CMD_STOP];
        csr_rd = bus_rd && bus_addr == ADDR_CSR;

        done   = st_q.busy && conv_valid;
        push   = done && !fifo_full;
        pop    = bus_rd && bus_addr == ADDR_FIFO && st_q.rd_hi && !fifo_empty;
        nx_idx = st_q.idx + 1'b1;
        last   = (({1'b0, st_q.idx} + 1'b1) == q_len);

        free_now   = 32'(FIFO_DEPTH) - 32'(fifo_count);
        free_after = free_now - 32'd1;
        nf_now     = free_now <= 32'(st_q.nf_val);
        thr_set    = push && !pop && !nf_now && (free_after <= 32'(st_q.nf_val));

        evt_set      = '0;
        evt_set.lost = done && fifo_full;
        evt_set.thr  = thr_set;
        evt_set.eos  = done && (last || nx_start);

        st_d       = st_q;
        st_d.start = 1'b0;

        if (bus_wr && bus_addr == ADDR_CSR) begin
            st_d.ctrl.eos_en = bus_wdata[CTL_EOS_EN];
            st_d.ctrl.thr_en = bus_wdata[CTL_THR_EN];
            st_d.ctrl.cont   = bus_wdata[CTL_CONT];
        end
        if (cmd_wr) st_d.data_mode = bus_wdata[CMD_DMODE];

        if (bus_wr && bus_addr == ADDR_FIFO && !st_q.data_mode && st_q.prog_cnt < 3'd4) begin
            st_d.prog_cnt = st_q.prog_cnt + 1'b1;
            if (st_q.prog_cnt == 3'd2) st_d.nf_lo  = bus_wdata;
            if (st_q.prog_cnt == 3'd3) st_d.nf_val = {bus_wdata, st_q.nf_lo};
        end
        if (bus_rd && bus_addr == ADDR_FIFO && !fifo_empty) st_d.rd_hi = !st_q.rd_hi;
        if (frst) begin
            st_d.prog_cnt = '0;
            st_d.rd_hi    = 1'b0;
        end

        if (done) begin
            st_d.busy = 1'b0;
            if (last) begin
                st_d.idx = '0;
                if (!st_q.ctrl.cont) st_d.running = 1'b0;
            end else begin
                st_d.idx = nx_idx;
            end
        end
        if (st_q.running && !st_q.busy && pacer_tick) begin
            st_d.start = 1'b1;
            st_d.busy  = 1'b1;
        end
        if (arm && q_len != '0) begin
            st_d.running = 1'b1;
            st_d.busy    = 1'b0;
            st_d.start   = 1'b0;
            st_d.idx     = '0;
        end
        if (stop || qrst) begin
            st_d.running = 1'b0;
            st_d.busy    = 1'b0;
            st_d.start   = 1'b0;
            st_d.idx     = '0;
        end

        st_d.evt = (csr_rd ? evt_t'('0) : st_q.evt) | evt_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.nf_val <= 16'(FIFO_DEPTH / 2);
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        status = {!st_q.running, st_q.running, st_q.evt.lost, st_q.evt.eos,
                  st_q.evt.thr, fifo_full, nf_now, fifo_empty};
        unique case (bus_addr)
            ADDR_FIFO:  bus_rdata = fifo_empty ? 8'h00 :
                                    (st_q.rd_hi ? fifo_head[15:8] : fifo_head[7:0]);
            ADDR_QUEUE: bus_rdata = 8'h00;
            ADDR_CSR:   bus_rdata = status;
            default:    bus_rdata = {7'd0, st_q.data_mode};
        endcase
    end

    assign running_w  = st_q.running;
    assign conv_start = st_q.start;
    assign irq = (st_q.ctrl.eos_en && st_q.evt.eos) || (st_q.ctrl.thr_en && st_q.evt.thr);
endmodule

// File: rtl/scan_acq_chk.sv
module scan_acq_chk #(
    parameter int FIFO_DEPTH = 4096,
    localparam int FC_W = $clog2(FIFO_DEPTH) + 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_rd,
    input logic [1:0]      bus_addr,
    input logic [7:0]      bus_rdata,
    input logic            conv_start,
    input logic            conv_valid,
    input logic            irq,
    input logic            running,
    input logic            fifo_full,
    input logic            fifo_empty,
    input logic [FC_W-1:0] fifo_count
);
    p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    p_start_running_r12: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(running));

    p_cmd_selfclear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd3) |-> (bus_rdata[7:1] == 7'd0));

    p_irq_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd2 && !conv_valid) |=> !irq);

    p_full_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= FC_W'(FIFO_DEPTH));
endmodule

bind scan_acq_seq scan_acq_chk #(.FIFO_DEPTH(FIFO_DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .conv_start(conv_start), .conv_valid(conv_valid),
    .irq(irq), .running(running_w), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .fifo_count(fifo_count)
);

// File: tb/scan_acq_seq_tb_top.sv
module scan_acq_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int FD = 8;
    localparam int QD = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        pacer_tick = 1'b0;
    logic        conv_start;
    logic [15:0] conv_entry;
    logic        conv_valid = 1'b0;
    logic [15:0] conv_data = '0;
    logic        irq;

    int checks = 0, fails = 0;
    bit finished = 0;
    logic [15:0] seq = 16'hA000;
    logic [15:0] seen [64];
    int n_starts = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scan_acq_seq #(.FIFO_DEPTH(FD), .QUEUE_DEPTH(QD)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pacer_tick(pacer_tick), .conv_start(conv_start), .conv_entry(conv_entry),
        .conv_valid(conv_valid), .conv_data(conv_data), .irq(irq)
    );

    // converter stub: answers one cycle after each start request
    always @(negedge clk) begin
        if (conv_start) begin
            if (n_starts < 64) seen[n_starts] = conv_entry;
            n_starts = n_starts + 1;
            conv_valid = 1'b1;
            conv_data = seq;
            seq = seq + 16'd1;
        end else begin
            conv_valid = 1'b0;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic put_entry(input logic [15:0] e);
        bus_write(2'd1, e[7:0]);
        bus_write(2'd1, e[15:8]);
    endtask

    task automatic get_word(output logic [15:0] w);
        logic [7:0] lo, hi;
        bus_read(2'd0, lo);
        bus_read(2'd0, hi);
        w = {hi, lo};
    endtask

    task automatic tick();
        @(negedge clk); pacer_tick = 1'b1;
        @(negedge clk); pacer_tick = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 irq", int'(irq), 0);
        bus_read(2'd2, d); check("R1 status", d, 8'h81);
        bus_read(2'd3, d); check("R1 cmd", d, 8'h00);
        bus_read(2'd0, d); check("R6 empty fifo read", d, 8'h00);
    endtask

    task automatic t_oneshot();
        logic [7:0] d; logic [15:0] w, base; int n0;
        put_entry(16'h4180); put_entry(16'h2205); put_entry(16'h13B0);
        bus_write(2'd2, 8'h00);
        bus_write(2'd3, 8'h81);
        bus_read(2'd2, d); check("R3 running after arm", d, 8'h41);
        base = seq; n0 = n_starts;
        tick(); check("R2 entry 0", int'(seen[n0]), 16'h4180);
        bus_read(2'd2, d); check("R5 no eos mid scan", d, 8'h40);
        tick(); check("R2 entry 1", int'(seen[n0+1]), 16'h2205);
        bus_read(2'd2, d); check("R5 eos before start entry", d, 8'h50);
        tick(); check("R2 entry 2", int'(seen[n0+2]), 16'h13B0);
        bus_read(2'd2, d); check("R3 idle after last, R5 eos", d, 8'h90);
        bus_read(2'd2, d); check("R7 events cleared", d, 8'h80);
        tick(); check("R3 no start when idle", n_starts, n0 + 3);
        get_word(w); check("R6 word 0", w, base);
        get_word(w); check("R6 word 1", w, base + 16'd1);
        get_word(w); check("R6 word 2", w, base + 16'd2);
        bus_read(2'd2, d); check("R6 empty after drain", d, 8'h81);
    endtask

    task automatic t_continuous();
        logic [7:0] d; int n0;
        bus_write(2'd3, 8'h20);
        put_entry(16'h0080); put_entry(16'h0101);
        bus_write(2'd2, 8'h04);
        bus_write(2'd3, 8'h40);
        bus_write(2'd3, 8'h81);
        n0 = n_starts;
        tick(); tick(); tick();
        check("R4 first", int'(seen[n0]), 16'h0080);
        check("R4 second", int'(seen[n0+1]), 16'h0101);
        check("R4 wrap", int'(seen[n0+2]), 16'h0080);
        bus_read(2'd2, d); check("R4 still running", int'(d & 8'hC0), 8'h40);
        bus_write(2'd3, 8'h11);
        tick(); check("R12 no start after stop", n_starts, n0 + 3);
        bus_read(2'd2, d); check("R12 idle", int'(d & 8'hC0), 8'h80);
        bus_read(2'd3, d); check("R8 cmd readback", d, 8'h01);
    endtask

    task automatic t_eos_irq();
        logic [7:0] d;
        bus_write(2'd3, 8'h40);
        bus_write(2'd2, 8'h10);
        bus_write(2'd3, 8'h81);
        tick(); check("R11 no irq mid scan", int'(irq), 0);
        tick(); check("R11 eos irq", int'(irq), 1);
        bus_read(2'd2, d); check("R11 eos status", int'(d & 8'h10), 8'h10);
        check("R11 irq cleared by read", int'(irq), 0);
    endtask

    task automatic t_threshold_overflow();
        logic [7:0] d; logic [15:0] w, base;
        bus_write(2'd3, 8'h20);
        put_entry(16'h0080);
        bus_write(2'd3, 8'h40);
        bus_write(2'd0, 8'h05); bus_write(2'd0, 8'h00);
        bus_write(2'd0, 8'h05); bus_write(2'd0, 8'h00);
        bus_write(2'd0, 8'h00); bus_write(2'd0, 8'h00);
        bus_write(2'd2, 8'h0C);
        bus_write(2'd3, 8'h81);
        base = seq;
        tick(); tick();
        check("R9 no irq below threshold", int'(irq), 0);
        bus_read(2'd2, d); check("R9 below threshold", d, 8'h50);
        tick();
        check("R11 threshold irq", int'(irq), 1);
        bus_read(2'd2, d); check("R9 threshold crossed", d, 8'h5A);
        check("R11 irq after read", int'(irq), 0);
        bus_read(2'd2, d); check("R7 live bits kept", d, 8'h42);
        repeat (5) tick();
        bus_read(2'd2, d); check("R10 full", d, 8'h56);
        tick();
        bus_read(2'd2, d); check("R10 data lost", d, 8'h76);
        bus_read(2'd2, d); check("R7 lost cleared", d, 8'h46);
        bus_write(2'd3, 8'h11);
        get_word(w); check("R10 oldest intact", w, base);
        for (int i = 1; i < FD; i++) get_word(w);
        check("R10 dropped word absent", w, base + 16'(FD - 1));
        bus_read(2'd2, d); check("R10 drained", d, 8'h81);
    endtask

    task automatic t_empty_queue();
        logic [7:0] d; int n0;
        bus_write(2'd3, 8'h20);
        bus_write(2'd3, 8'h40);
        bus_write(2'd3, 8'h81);
        bus_read(2'd2, d); check("R13 arm ignored", d, 8'h81);
        n0 = n_starts;
        tick(); check("R13 no start", n_starts, n0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_oneshot();
        t_continuous();
        t_eos_irq();
        t_threshold_overflow();
        t_empty_queue();
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule